// File: doc/BRIEF.md
# Scaled Radix-2 Butterfly Stage

This block is one pipelined radix-2 stage of a fixed-point complex FFT. Each valid input beat carries two complex operands, A and B, whose twiddle multiplication has already been done upstream. The stage returns the complex sum A+B and the complex difference A−B. All values are signed two's complement.

Growth handling is chosen beat by beat through a two-bit mode input, which travels down the pipeline with its beat. In the first mode the extra bit of the add is kept. In the second mode the result is halved with rounding. In the third mode the result is clamped back into the input width. Valid, start-of-frame and end-of-frame flags pass through exactly the same delay as the data, so a downstream stage sees frames intact.

For each frame the stage also reports how many result components it clamped and whether any beat of the frame was halved. This lets a chain of stages show where the range first ran out.

Top module: `bfly_stage`

## Requirements
- R1: Every result appears exactly two clock cycles after its input beat. `out_vld`, `out_sof` and `out_eof` carry the input flags of that same beat with the same two-cycle delay.
- R2: With mode 2'b00, `sum_*` equals A+B and `dif_*` equals A−B exactly, as W+1-bit signed values, including the extreme input codes.
- R3: With mode 2'b01, each component x (sum or difference) is output as floor((x+1)/2), which is halving with round-half-up. The result is sign-extended onto the W+1-bit port.
- R4: With mode 2'b01, a rounded result above 2^(W-1)−1 is replaced by 2^(W-1)−1 and counts as one clamp event.
- R5: With mode 2'b10, each component is clamped into [−2^(W−1), 2^(W−1)−1] and sign-extended onto the port. Each component that is clamped counts as one clamp event.
- R6: The reserved mode 2'b11 behaves exactly like mode 2'b00.
- R7: `sat_cnt` is loaded on the output beat that carries end-of-frame. It holds the number of clamp events from the start-of-frame beat through that beat, and starts again from zero at every start-of-frame. A beat that carries both flags is a frame on its own. `sat_cnt` does not change at any other time.
- R8: `scaled` is loaded at the same moment as `sat_cnt`. It is 1 if any beat of the frame used mode 2'b01, and 0 otherwise.
- R9: The mode is captured together with its beat, so beats of one frame may use different modes and each beat is processed under its own mode.
- R10: After reset, all outputs, including the status outputs, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Growth mode of this beat: 00 keep, 01 halve, 10 clamp, 11 keep |
| in_vld | input | 1 | Input beat valid |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eof | input | 1 | Beat is the last of a frame |
| a_re | input | W | Operand A, real part |
| a_im | input | W | Operand A, imaginary part |
| b_re | input | W | Operand B, real part |
| b_im | input | W | Operand B, imaginary part |
| out_vld | output | 1 | Result valid |
| out_sof | output | 1 | Result is the first of a frame |
| out_eof | output | 1 | Result is the last of a frame |
| sum_re | output | W+1 | Real part of A+B |
| sum_im | output | W+1 | Imaginary part of A+B |
| dif_re | output | W+1 | Real part of A−B |
| dif_im | output | W+1 | Imaginary part of A−B |
| sat_cnt | output | CW | Clamp events of the last completed frame |
| scaled | output | 1 | Last completed frame used halving |

## Verification
The assertions assume well-formed framing: every frame opens with a start-of-frame beat and closes with an end-of-frame beat, and all flags are low on beats that are not valid. The stimulus only builds frames this way, including single-beat frames and frames that follow each other back to back. The flag inputs are held low while reset is asserted and during idle gaps. The operands cover the full signed range on purpose, so the rounding and clamping assertions see both rails.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  typedef enum logic [1:0] {
    MODE_GROW = 2'b00,
    MODE_HALF = 2'b01,
    MODE_CLIP = 2'b10,
    MODE_ALT  = 2'b11
  } bfly_mode_e;

  localparam int NCOMP = 4;  // sum re/im, difference re/im
endpackage

// File: rtl/bfly_addsub.sv
module bfly_addsub
  import bfly_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic                     in_vld,
  input  logic                     in_sof,
  input  logic                     in_eof,
  input  logic [W-1:0]             a_re,
  input  logic [W-1:0]             a_im,
  input  logic [W-1:0]             b_re,
  input  logic [W-1:0]             b_im,
  output logic                     s1_vld,
  output logic                     s1_sof,
  output logic                     s1_eof,
  output bfly_mode_e               s1_mode,
  output logic [NCOMP-1:0][W:0]    s1_full
);
  function automatic logic [W:0] widen(input logic [W-1:0] v);
    return {v[W-1], v};
  endfunction

  logic [NCOMP-1:0][W:0] full_c;

  always_comb begin
    full_c[0] = widen(a_re) + widen(b_re);
    full_c[1] = widen(a_im) + widen(b_im);
    full_c[2] = widen(a_re) - widen(b_re);
    full_c[3] = widen(a_im) - widen(b_im);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_sof  <= 1'b0;
      s1_eof  <= 1'b0;
      s1_mode <= MODE_GROW;
      s1_full <= '0;
    end else begin
      s1_vld  <= in_vld;
      s1_sof  <= in_sof & in_vld;
      s1_eof  <= in_eof & in_vld;
      s1_mode <= bfly_mode_e'(mode);
      s1_full <= full_c;
    end
  end

  // R2: adding two operands of equal sign never flips the sign of the full sum
  p_grow_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && $past(a_re[W-1]) == $past(b_re[W-1])) |-> s1_full[0][W] == $past(a_re[W-1]));
endmodule

// File: rtl/bfly_scale.sv
module bfly_scale
  import bfly_pkg::*;
#(
  parameter int W = 16
) (
  input  bfly_mode_e  mode,
  input  logic [W:0]  full,
  output logic [W:0]  res,
  output logic        clamp
);
  localparam logic signed [W+1:0] HI = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [W+1:0] LO = {3'b111, {(W-1){1'b0}}};

  function automatic logic signed [W+1:0] half_up(input logic [W:0] x);
    logic [W+1:0] t;
    t = {x[W], x} + {{(W+1){1'b0}}, 1'b1};
    return $signed(t) >>> 1;
  endfunction

  function automatic logic [W-1:0] clip_w(input logic signed [W+1:0] v);
    if (v > HI) return HI[W-1:0];
    else if (v < LO) return LO[W-1:0];
    else return v[W-1:0];
  endfunction

  logic signed [W+1:0] wide;
  logic                narrow;
  logic                out_of_range;
  logic [W-1:0]        clipped;

  always_comb begin
    wide         = (mode == MODE_HALF) ? half_up(full) : $signed({full[W], full});
    narrow       = (mode == MODE_HALF) || (mode == MODE_CLIP);
    out_of_range = (wide > HI) || (wide < LO);
    clamp        = narrow && out_of_range;
    clipped      = clip_w(wide);
    res          = narrow ? {clipped[W-1], clipped} : full;
  end

  always_comb begin
    // R5: a clamped component sits exactly on one of the two rails
    p_clamp_rail_r5: assert (!clamp || res == {HI[W-1], HI[W-1:0]} || res == {LO[W-1], LO[W-1:0]});
    // R3: narrow modes yield a value representable in W bits
    p_narrow_fit_r3: assert (!narrow || res[W] == res[W-1]);
  end
endmodule

// File: rtl/bfly_frame_stat.sv
module bfly_frame_stat
  import bfly_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld,
  input  logic              beat_sof,
  input  logic              beat_eof,
  input  logic [NCOMP-1:0]  beat_clamp,
  input  logic              beat_half,
  output logic [CW-1:0]     sat_cnt,
  output logic              scaled
);
  localparam int NW = $clog2(NCOMP + 1);

  logic [CW-1:0] run_cnt;
  logic          run_scl;
  logic [NW-1:0] n_clamp;
  logic [CW-1:0] base_cnt;
  logic [CW:0]   sum_cnt;
  logic [CW-1:0] next_cnt;
  logic          next_scl;

  always_comb begin
    n_clamp = '0;
    for (int i = 0; i < NCOMP; i++) n_clamp = n_clamp + NW'(beat_clamp[i]);
    base_cnt = beat_sof ? '0 : run_cnt;
    sum_cnt  = {1'b0, base_cnt} + (CW+1)'(n_clamp);
    next_cnt = sum_cnt[CW] ? '1 : sum_cnt[CW-1:0];
    next_scl = (beat_sof ? 1'b0 : run_scl) | beat_half;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      run_scl <= 1'b0;
      sat_cnt <= '0;
      scaled  <= 1'b0;
    end else if (beat_vld) begin
      run_cnt <= next_cnt;
      run_scl <= next_scl;
      if (beat_eof) begin
        sat_cnt <= next_cnt;
        scaled  <= next_scl;
      end
    end
  end

  // R7: status only moves on an end-of-frame beat
  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_vld && beat_eof) |=> $stable(sat_cnt) && $stable(scaled));
  // R8: a halved end-of-frame beat always reports scaling
  p_scaled_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && beat_eof && beat_half) |=> scaled);
  // R7: a clean single-beat frame reports zero clamps
  p_sof_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && beat_sof && beat_eof && beat_clamp == '0) |=> sat_cnt == '0);
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage
  import bfly_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          in_vld,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [W-1:0]  a_re,
  input  logic [W-1:0]  a_im,
  input  logic [W-1:0]  b_re,
  input  logic [W-1:0]  b_im,
  output logic          out_vld,
  output logic          out_sof,
  output logic          out_eof,
  output logic [W:0]    sum_re,
  output logic [W:0]    sum_im,
  output logic [W:0]    dif_re,
  output logic [W:0]    dif_im,
  output logic [CW-1:0] sat_cnt,
  output logic          scaled
);
  logic                   s1_vld, s1_sof, s1_eof;
  bfly_mode_e             s1_mode;
  logic [NCOMP-1:0][W:0]  s1_full;
  logic [NCOMP-1:0][W:0]  scaled_c;
  logic [NCOMP-1:0]       clamp_c;
  logic [NCOMP-1:0][W:0]  s2_data;
  bfly_mode_e             s2_mode;
  logic [1:0]             warm;

  bfly_addsub #(.W(W)) i_addsub (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .in_vld(in_vld), .in_sof(in_sof), .in_eof(in_eof),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .s1_vld(s1_vld), .s1_sof(s1_sof), .s1_eof(s1_eof),
    .s1_mode(s1_mode), .s1_full(s1_full)
  );

  for (genvar g = 0; g < NCOMP; g++) begin : g_scale
    bfly_scale #(.W(W)) i_scale (
      .mode(s1_mode), .full(s1_full[g]),
      .res(scaled_c[g]), .clamp(clamp_c[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_sof <= 1'b0;
      out_eof <= 1'b0;
      s2_data <= '0;
      s2_mode <= MODE_GROW;
    end else begin
      out_vld <= s1_vld;
      out_sof <= s1_sof;
      out_eof <= s1_eof;
      s2_data <= scaled_c;
      s2_mode <= s1_mode;
    end
  end

  assign sum_re = s2_data[0];
  assign sum_im = s2_data[1];
  assign dif_re = s2_data[2];
  assign dif_im = s2_data[3];

  bfly_frame_stat #(.CW(CW)) i_stat (
    .clk(clk), .rst_n(rst_n),
    .beat_vld(s1_vld), .beat_sof(s1_sof), .beat_eof(s1_eof),
    .beat_clamp(s1_vld ? clamp_c : '0),
    .beat_half(s1_vld && s1_mode == MODE_HALF),
    .sat_cnt(sat_cnt), .scaled(scaled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R1: valid and frame flags emerge two cycles after entry
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (out_vld == $past(in_vld, 2)) &&
                       (out_sof == $past(in_sof && in_vld, 2)) &&
                       (out_eof == $past(in_eof && in_vld, 2)));
  // R5: narrow modes never drive a word needing the growth bit
  p_narrow_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && (s2_mode == MODE_HALF || s2_mode == MODE_CLIP)) |->
      (sum_re[W] == sum_re[W-1]) && (sum_im[W] == sum_im[W-1]) &&
      (dif_re[W] == dif_re[W-1]) && (dif_im[W] == dif_im[W-1]));
  // R1: frame flags only appear on valid results
  p_flag_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof) |-> out_vld);
endmodule

// File: tb/test_bfly_stage.sv
`timescale 1ns/1ps
module test_bfly_stage;
  localparam int W  = 16;
  localparam int CW = 16;
  localparam int HI = 2**(W-1) - 1;
  localparam int LO = -(2**(W-1));

  typedef struct {
    int  s_re, s_im, d_re, d_im;
    bit  sof, eof;
    int  cyc;
    int  cnt;
    bit  scl;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          in_vld = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [W-1:0]  a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic          out_vld, out_sof, out_eof;
  logic [W:0]    sum_re, sum_im, dif_re, dif_im;
  logic [CW-1:0] sat_cnt;
  logic          scaled;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  exp_t q[$];
  int run_cnt = 0;
  bit run_scl = 0;
  int last_cnt = 0;
  bit last_scl = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bfly_stage #(.W(W), .CW(CW)) i_bfly_stage (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .in_vld(in_vld), .in_sof(in_sof), .in_eof(in_eof),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_vld(out_vld), .out_sof(out_sof), .out_eof(out_eof),
    .sum_re(sum_re), .sum_im(sum_im), .dif_re(dif_re), .dif_im(dif_im),
    .sat_cnt(sat_cnt), .scaled(scaled)
  );

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  // bench model of one component under a mode; returns value and clamp flag
  function automatic int model(input logic [1:0] m, input int x, output bit clp);
    int v;
    clp = 0;
    if (m == 2'b01) v = (x + 1) >>> 1;
    else v = x;
    if (m == 2'b01 || m == 2'b10) begin
      if (v > HI) begin v = HI; clp = 1; end
      else if (v < LO) begin v = LO; clp = 1; end
    end
    return v;
  endfunction

  task automatic beat(input logic [1:0] m, input int ar, input int ai, input int br, input int bi,
                      input bit sof, input bit eof);
    exp_t e;
    bit c0, c1, c2, c3;
    @(negedge clk);
    mode = m; in_vld = 1'b1; in_sof = sof; in_eof = eof;
    a_re = W'(ar); a_im = W'(ai); b_re = W'(br); b_im = W'(bi);
    e.s_re = model(m, ar + br, c0);
    e.s_im = model(m, ai + bi, c1);
    e.d_re = model(m, ar - br, c2);
    e.d_im = model(m, ai - bi, c3);
    e.sof = sof; e.eof = eof; e.cyc = cyc;
    if (sof) begin run_cnt = 0; run_scl = 0; end
    run_cnt += int'(c0) + int'(c1) + int'(c2) + int'(c3);
    run_scl |= (m == 2'b01);
    e.cnt = run_cnt; e.scl = run_scl;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      mode = 2'b11; a_re = 16'h7fff; b_re = 16'h7fff; a_im = 16'h8000; b_im = 16'h8000;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && out_vld) begin
        if (q.size() == 0) begin
          chk(0, "R1", "unexpected output beat", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc - e.cyc == 2, "R1", "latency", cyc - e.cyc, 2);
          chk(out_sof == e.sof && out_eof == e.eof, "R1", "frame flags",
              {out_sof, out_eof}, {e.sof, e.eof});
          chk($signed(sum_re) == e.s_re, "R2-R6,R9 sum_re", "data", $signed(sum_re), e.s_re);
          chk($signed(sum_im) == e.s_im, "R2-R6,R9 sum_im", "data", $signed(sum_im), e.s_im);
          chk($signed(dif_re) == e.d_re, "R2-R6,R9 dif_re", "data", $signed(dif_re), e.d_re);
          chk($signed(dif_im) == e.d_im, "R2-R6,R9 dif_im", "data", $signed(dif_im), e.d_im);
          if (e.eof) begin last_cnt = e.cnt; last_scl = e.scl; end
          // R7 R8: status loaded on eof, held on every other beat
          chk(int'(sat_cnt) == last_cnt, "R7", "sat_cnt", sat_cnt, last_cnt);
          chk(scaled == last_scl, "R8", "scaled", scaled, last_scl);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(1);
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(out_vld == 0 && out_sof == 0 && out_eof == 0, "R10", "flags", {out_vld, out_sof, out_eof}, 0);
    chk(sum_re == 0 && sum_im == 0 && dif_re == 0 && dif_im == 0, "R10", "data",
        sum_re | sum_im | dif_re | dif_im, 0);
    chk(sat_cnt == 0 && scaled == 0, "R10", "status", sat_cnt, 0);

    // R2: full growth, extremes
    beat(2'b00, 100, -200, 50, 7, 1, 0);
    beat(2'b00, HI, HI, LO, LO, 0, 0);
    beat(2'b00, LO, HI, HI, LO, 0, 1);
    idle(2);
    // R3 R4: halving with round-half-up and overflow clamp
    beat(2'b01, 3, -3, 0, 0, 1, 0);
    beat(2'b01, -3, 5, 0, -2, 0, 0);
    beat(2'b01, HI, 0, LO, 0, 0, 0);
    beat(2'b01, LO, LO, LO, LO, 0, 1);
    idle(1);
    // R5: clamp to input width
    beat(2'b10, 30000, -30000, 10000, -10000, 1, 0);
    idle(1);
    beat(2'b10, 1, 2, 3, 4, 0, 0);
    beat(2'b10, HI, LO, LO, HI, 0, 1);
    // R6: reserved mode keeps growth, single-beat frame
    beat(2'b11, HI, HI, HI, HI, 1, 1);
    // R9: mixed modes within one frame
    beat(2'b10, 30000, 0, 30000, 0, 1, 0);
    beat(2'b00, 30000, 0, 30000, 0, 0, 0);
    idle(2);
    beat(2'b01, 30000, 0, 30000, 0, 0, 1);
    // R7: counter restarts at next sof, back to back
    beat(2'b10, -30000, 0, 10000, 0, 1, 1);
    beat(2'b00, 1, 1, 1, 1, 1, 0);
    beat(2'b00, -1, -1, 1, 1, 0, 1);
    idle(6);
    chk(q.size() == 0, "R1", "pending results", q.size(), 0);
    // R7 R8: status holds while idle
    chk(int'(sat_cnt) == last_cnt && scaled == last_scl, "R7", "status hold", sat_cnt, last_cnt);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule